// File: doc/BRIEF.md
# Single Address/Data Match Trigger

This block is the hardware breakpoint unit of a 32-bit RISC-V style core. It has exactly one match trigger. A debugger or machine-mode software programs it with CSR-style reads and writes: a selector register, a match-control register, a compare-value register and a capability register. Four fixed 12-bit CSR numbers reach these registers.

Once armed, the unit watches the instruction fetch stream (PC and opcode) and the completed load/store stream (address and data). It compares the chosen quantity for full 32-bit equality against the compare value. On a hit it emits a one-cycle request in the next cycle. That request is either a breakpoint exception with cause code 3 or a debug-mode entry request. Alongside it the unit gives the PC the core must record. Instruction hits report the PC of the instruction that has not yet executed. Load/store hits report the following instruction address, since the access has already completed.

The core supplies a debug-mode flag. This flag turns matching off. It is also the only context in which the trigger can be claimed for the debugger, and a claimed trigger is write-locked against code running outside debug mode.

Top module: `dbg_trigger_unit`

## Requirements
- R1: After reset, the match-control register (CSR 0x7A1) reads 0x2000_0000, meaning kind field 2 with all enables clear. The compare value (CSR 0x7A2) reads 0. No request output is active.
- R2: The selector (CSR 0x7A0) always reads 0 and the capability register (CSR 0x7A4) always reads 4. Writes to either have no visible effect.
- R3: Match-control bit positions are: kind [31:28], debugger-owned flag [27], data-select [19], action [15:12], machine-enable [6], execute [2], store [1], load [0]. All other bits read 0. A written kind of 0 reads back as 0 and any other kind reads back as 2. A written action of 1 reads 1 and any other action reads 0.
- R4: The debugger-owned flag can be set only by a write made while debug_mode_i is 1. While the flag is 1 and debug_mode_i is 0, writes to match control and to the compare value are ignored.
- R5: The {data-select, execute, store, load} fields select the match kind: 0100 is fetch PC, 1100 is fetch opcode, 0010 is store address, 1010 is store data, 0001 is load address, 1001 is load data. Every other combination never produces a request.
- R6: For the fetch kinds, a cycle with if_valid_i high and an equal PC or opcode produces a request in the next cycle, with exc_pc_o equal to that fetch's PC.
- R7: For the load/store kinds, a cycle with mem_valid_i high, the right direction (mem_store_i 1 for store, 0 for load) and an equal address or data produces a request in the next cycle, with exc_pc_o equal to mem_pc_i + 4. An access in the opposite direction produces no request.
- R8: Action 0 gives brk_exc_o with exc_cause_o = 3. Action 1 gives dbg_req_o with exc_cause_o = 0. The two outputs are never high together. Each matching strobe gives exactly one high cycle.
- R9: No request is produced for a strobe seen while debug_mode_i is 1, while machine-enable is 0, or while the kind field is 0.
- R10: csr_rdata_o follows csr_addr_i within the same cycle. Any CSR number outside the four above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| debug_mode_i | input | 1 | Core is in debug mode |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR number for read and write |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (combinational) |
| if_valid_i | input | 1 | Fetch strobe: instruction about to execute |
| if_pc_i | input | 32 | PC of the fetched instruction |
| if_insn_i | input | 32 | Opcode of the fetched instruction |
| mem_valid_i | input | 1 | Completed load/store strobe |
| mem_store_i | input | 1 | 1 for a store, 0 for a load |
| mem_pc_i | input | 32 | PC of the load/store instruction |
| mem_addr_i | input | 32 | Load/store address |
| mem_data_i | input | 32 | Data stored or loaded |
| brk_exc_o | output | 1 | One-cycle breakpoint exception request |
| dbg_req_o | output | 1 | One-cycle debug-mode entry request |
| exc_cause_o | output | 4 | 3 while brk_exc_o is high, otherwise 0 |
| exc_pc_o | output | 32 | PC to record; updated on each request and held otherwise |

## Verification
The assertions assume that debug_mode_i and the strobes are stable around the clock edge. They also assume that a request cycle follows the strobe that caused it, with no CSR write between them that could change the arming. The bench drives every input on the falling edge. It changes match control only through completed CSR writes, and it leaves an idle cycle after each strobe so that each request can be tied to a single cause. Fetch and load/store strobes are issued together only where the illegal-kind case needs both paths to show no hit at once.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // CSR numbers of the trigger registers
  localparam logic [11:0] A_TSEL  = 12'h7A0;
  localparam logic [11:0] A_TCTL  = 12'h7A1;
  localparam logic [11:0] A_TCMP  = 12'h7A2;
  localparam logic [11:0] A_TINFO = 12'h7A4;

  // match-control bit positions below the kind/owner fields
  localparam int unsigned B_SEL  = 19;
  localparam int unsigned B_ACT  = 12;
  localparam int unsigned W_ACT  = 4;
  localparam int unsigned B_MEN  = 6;
  localparam int unsigned B_EXE  = 2;
  localparam int unsigned B_ST   = 1;
  localparam int unsigned B_LD   = 0;

  localparam logic [3:0] KIND_MATCH = 4'd2;
  localparam logic [3:0] INFO_VAL   = 4'd4;
  localparam logic [3:0] CAUSE_BRK  = 4'd3;

  typedef enum logic [2:0] {
    MK_NONE, MK_IPC, MK_IOPC, MK_SADDR, MK_SDATA, MK_LADDR, MK_LDATA
  } match_kind_e;

  typedef struct packed {
    logic kind_on;   // kind field nonzero (reads as 2)
    logic owned;     // debugger-owned
    logic dsel;      // data instead of address
    logic act_dbg;   // action: debug entry
    logic men;       // machine-mode enable
    logic exe;
    logic st;
    logic ld;
  } tctl_t;

endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/trig_regs.sv
module trig_regs
  import trig_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            debug_mode_i,
  input  logic            csr_we_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output tctl_t           ctl_o,
  output logic [XLEN-1:0] cmp_o
);
  localparam int unsigned KIND_HI = XLEN - 1;
  localparam int unsigned KIND_LO = XLEN - 4;
  localparam int unsigned B_OWN   = XLEN - 5;

  tctl_t           ctl_q, ctl_d;
  logic [XLEN-1:0] cmp_q, cmp_d;
  logic            wr_ok, ctl_en, cmp_en;
  logic [XLEN-1:0] ctl_img, ctl_mask;

  // write permission: owned trigger is locked outside debug mode
  always_comb begin
    wr_ok  = !ctl_q.owned || debug_mode_i;
    ctl_en = csr_we_i && (csr_addr_i == AW'(A_TCTL)) && wr_ok;
    cmp_en = csr_we_i && (csr_addr_i == AW'(A_TCMP)) && wr_ok;
  end

  // legalised next value of match control
  always_comb begin
    ctl_d         = ctl_q;
    ctl_d.kind_on = |csr_wdata_i[KIND_HI:KIND_LO];
    ctl_d.owned   = csr_wdata_i[B_OWN] && debug_mode_i;
    ctl_d.dsel    = csr_wdata_i[B_SEL];
    ctl_d.act_dbg = (csr_wdata_i[B_ACT+W_ACT-1:B_ACT] == W_ACT'(1));
    ctl_d.men     = csr_wdata_i[B_MEN];
    ctl_d.exe     = csr_wdata_i[B_EXE];
    ctl_d.st      = csr_wdata_i[B_ST];
    ctl_d.ld      = csr_wdata_i[B_LD];
    cmp_d         = csr_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{kind_on: 1'b1, default: 1'b0};
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_en) cmp_q <= cmp_d;
  end

  // read image of match control
  always_comb begin
    ctl_img                  = '0;
    ctl_img[KIND_HI:KIND_LO] = ctl_q.kind_on ? KIND_MATCH : 4'd0;
    ctl_img[B_OWN]           = ctl_q.owned;
    ctl_img[B_SEL]           = ctl_q.dsel;
    ctl_img[B_ACT]           = ctl_q.act_dbg;
    ctl_img[B_MEN]           = ctl_q.men;
    ctl_img[B_EXE]           = ctl_q.exe;
    ctl_img[B_ST]            = ctl_q.st;
    ctl_img[B_LD]            = ctl_q.ld;
  end

  always_comb begin
    unique case (csr_addr_i)
      AW'(A_TCTL):  csr_rdata_o = ctl_img;
      AW'(A_TCMP):  csr_rdata_o = cmp_q;
      AW'(A_TINFO): csr_rdata_o = XLEN'(INFO_VAL);
      default:      csr_rdata_o = '0;
    endcase
  end

  assign ctl_o = ctl_q;
  assign cmp_o = cmp_q;

  always_comb begin
    ctl_mask                  = '0;
    ctl_mask[KIND_HI:KIND_LO] = '1;
    ctl_mask[B_OWN]           = 1'b1;
    ctl_mask[B_SEL]           = 1'b1;
    ctl_mask[B_ACT]           = 1'b1;
    ctl_mask[B_MEN]           = 1'b1;
    ctl_mask[B_EXE]           = 1'b1;
    ctl_mask[B_ST]            = 1'b1;
    ctl_mask[B_LD]            = 1'b1;
  end

  // R3
  ctl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr_i == AW'(A_TCTL)) |-> ((csr_rdata_o & ~ctl_mask) == '0));

  // R2
  sel_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr_i == AW'(A_TSEL)) |-> (csr_rdata_o == '0));

  // R4
  owned_cmp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_addr_i == AW'(A_TCMP) && ctl_q.owned && !debug_mode_i)
      |=> $stable(cmp_q));

  // R4
  owned_only_in_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.owned) |-> $past(debug_mode_i));
endmodule

// File: rtl/trig_match.sv
module trig_match
  import trig_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tctl_t           ctl_i,
  input  logic [XLEN-1:0] cmp_i,
  input  logic            debug_mode_i,
  input  logic            if_valid_i,
  input  logic [XLEN-1:0] if_pc_i,
  input  logic [XLEN-1:0] if_insn_i,
  input  logic            mem_valid_i,
  input  logic            mem_store_i,
  input  logic [XLEN-1:0] mem_pc_i,
  input  logic [XLEN-1:0] mem_addr_i,
  input  logic [XLEN-1:0] mem_data_i,
  output logic            hit_o,
  output logic [XLEN-1:0] hit_pc_o
);
  localparam int unsigned N_OPS = 4;
  localparam int unsigned OP_PC = 0, OP_INSN = 1, OP_ADDR = 2, OP_DATA = 3;

  match_kind_e     kind;
  logic            armed;
  logic [XLEN-1:0] ops [N_OPS];
  logic [N_OPS-1:0] eq;

  assign ops[OP_PC]   = if_pc_i;
  assign ops[OP_INSN] = if_insn_i;
  assign ops[OP_ADDR] = mem_addr_i;
  assign ops[OP_DATA] = mem_data_i;

  // one full-width equality comparator per watched quantity
  for (genvar g = 0; g < N_OPS; g++) begin : g_cmp
    assign eq[g] = (ops[g] == cmp_i);
  end

  always_comb begin
    unique case ({ctl_i.dsel, ctl_i.exe, ctl_i.st, ctl_i.ld})
      4'b0100: kind = MK_IPC;
      4'b1100: kind = MK_IOPC;
      4'b0010: kind = MK_SADDR;
      4'b1010: kind = MK_SDATA;
      4'b0001: kind = MK_LADDR;
      4'b1001: kind = MK_LDATA;
      default: kind = MK_NONE;
    endcase
  end

  assign armed = ctl_i.men && ctl_i.kind_on && !debug_mode_i;

  always_comb begin
    logic raw;
    logic after;
    raw   = 1'b0;
    after = 1'b0;
    unique case (kind)
      MK_IPC:   raw = if_valid_i && eq[OP_PC];
      MK_IOPC:  raw = if_valid_i && eq[OP_INSN];
      MK_SADDR: begin raw = mem_valid_i &&  mem_store_i && eq[OP_ADDR]; after = 1'b1; end
      MK_SDATA: begin raw = mem_valid_i &&  mem_store_i && eq[OP_DATA]; after = 1'b1; end
      MK_LADDR: begin raw = mem_valid_i && !mem_store_i && eq[OP_ADDR]; after = 1'b1; end
      MK_LDATA: begin raw = mem_valid_i && !mem_store_i && eq[OP_DATA]; after = 1'b1; end
      default:  raw = 1'b0;
    endcase
    hit_o    = armed && raw;
    hit_pc_o = after ? (mem_pc_i + XLEN'(INSN_BYTES)) : if_pc_i;
  end

  // R5
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ($countones({ctl_i.exe, ctl_i.st, ctl_i.ld}) == 1));

  // R7
  mem_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !ctl_i.exe) |-> (mem_valid_i && (mem_store_i == ctl_i.st)));
endmodule

// File: rtl/trig_fire.sv
module trig_fire
  import trig_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            debug_mode_i,
  input  logic            hit_i,
  input  logic            act_dbg_i,
  input  logic [XLEN-1:0] hit_pc_i,
  output logic            brk_exc_o,
  output logic            dbg_req_o,
  output logic [3:0]      exc_cause_o,
  output logic [XLEN-1:0] exc_pc_o
);
  logic            brk_q, brk_d, dbg_q, dbg_d;
  logic [3:0]      cause_q, cause_d;
  logic [XLEN-1:0] pc_q, pc_d;

  always_comb begin
    brk_d   = hit_i && !act_dbg_i;
    dbg_d   = hit_i &&  act_dbg_i;
    cause_d = brk_d ? CAUSE_BRK : 4'd0;
    pc_d    = hit_pc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q   <= 1'b0;
      dbg_q   <= 1'b0;
      cause_q <= 4'd0;
    end else begin
      brk_q   <= brk_d;
      dbg_q   <= dbg_d;
      cause_q <= cause_d;
    end
  end

  // recorded PC only loads on a hit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (hit_i) pc_q <= pc_d;
  end

  assign brk_exc_o   = brk_q;
  assign dbg_req_o   = dbg_q;
  assign exc_cause_o = cause_q;
  assign exc_pc_o    = pc_q;

  // R8
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_exc_o && dbg_req_o));

  // R9
  debug_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode_i |=> !(brk_exc_o || dbg_req_o));

  // R8
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_exc_o || dbg_req_o) |-> $past(hit_i));
endmodule

// File: rtl/dbg_trigger_unit.sv
module dbg_trigger_unit
  import trig_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned AW         = 12,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned SYNC_STG   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            debug_mode_i,
  input  logic            csr_we_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic            if_valid_i,
  input  logic [XLEN-1:0] if_pc_i,
  input  logic [XLEN-1:0] if_insn_i,
  input  logic            mem_valid_i,
  input  logic            mem_store_i,
  input  logic [XLEN-1:0] mem_pc_i,
  input  logic [XLEN-1:0] mem_addr_i,
  input  logic [XLEN-1:0] mem_data_i,
  output logic            brk_exc_o,
  output logic            dbg_req_o,
  output logic [3:0]      exc_cause_o,
  output logic [XLEN-1:0] exc_pc_o
);
  logic            rst_sync_n;
  tctl_t           ctl;
  logic [XLEN-1:0] cmp;
  logic            hit;
  logic [XLEN-1:0] hit_pc;

  trig_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  trig_regs #(.XLEN(XLEN), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .debug_mode_i(debug_mode_i),
    .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i),
    .csr_rdata_o(csr_rdata_o), .ctl_o(ctl), .cmp_o(cmp)
  );

  trig_match #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_match (
    .clk(clk), .rst_n(rst_sync_n), .ctl_i(ctl), .cmp_i(cmp),
    .debug_mode_i(debug_mode_i),
    .if_valid_i(if_valid_i), .if_pc_i(if_pc_i), .if_insn_i(if_insn_i),
    .mem_valid_i(mem_valid_i), .mem_store_i(mem_store_i), .mem_pc_i(mem_pc_i),
    .mem_addr_i(mem_addr_i), .mem_data_i(mem_data_i),
    .hit_o(hit), .hit_pc_o(hit_pc)
  );

  trig_fire #(.XLEN(XLEN)) u_fire (
    .clk(clk), .rst_n(rst_sync_n), .debug_mode_i(debug_mode_i),
    .hit_i(hit), .act_dbg_i(ctl.act_dbg), .hit_pc_i(hit_pc),
    .brk_exc_o(brk_exc_o), .dbg_req_o(dbg_req_o),
    .exc_cause_o(exc_cause_o), .exc_pc_o(exc_pc_o)
  );

  // R9
  armed_before_fire_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (brk_exc_o || dbg_req_o) |-> ($past(ctl.men) && $past(ctl.kind_on)));

  // R6
  fetch_pc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && ctl.exe) |=> (exc_pc_o == $past(if_pc_i)));

  // R7
  mem_pc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit && !ctl.exe) |=> (exc_pc_o == $past(mem_pc_i) + XLEN'(INSN_BYTES)));

  // R8
  brk_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_exc_o |-> (exc_cause_o == CAUSE_BRK));
endmodule

// File: tb/dbg_trigger_unit_test.sv
`timescale 1ns/1ps
module dbg_trigger_unit_test;
  localparam logic [11:0] TSEL = 12'h7A0, TCTL = 12'h7A1, TCMP = 12'h7A2, TINFO = 12'h7A4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic debug_mode = 1'b0;
  logic csr_we = 1'b0;
  logic [11:0] csr_addr = 12'h0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic if_valid = 1'b0;
  logic [31:0] if_pc = '0, if_insn = '0;
  logic mem_valid = 1'b0, mem_store = 1'b0;
  logic [31:0] mem_pc = '0, mem_addr = '0, mem_data = '0;
  logic brk, dbg;
  logic [3:0] cause;
  logic [31:0] xpc;

  int total = 0;
  int bad = 0;
  bit live = 0;
  bit done = 0;

  typedef struct {
    logic        brk;
    logic        dbg;
    logic [31:0] pc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  dbg_trigger_unit uut (
    .clk(clk), .rst_n(rst_n), .debug_mode_i(debug_mode),
    .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata),
    .if_valid_i(if_valid), .if_pc_i(if_pc), .if_insn_i(if_insn),
    .mem_valid_i(mem_valid), .mem_store_i(mem_store), .mem_pc_i(mem_pc),
    .mem_addr_i(mem_addr), .mem_data_i(mem_data),
    .brk_exc_o(brk), .dbg_req_o(dbg), .exc_cause_o(cause), .exc_pc_o(xpc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    csr_addr = a;
    #1;
    check(csr_rdata == exp, tag, csr_rdata, exp);
  endtask

  // one strobe cycle on the fetch and/or load/store side; expectation goes to the scoreboard
  task automatic strobe(input bit fv, input logic [31:0] pc, input logic [31:0] insn,
                        input bit mv, input bit st, input logic [31:0] mpc,
                        input logic [31:0] ma, input logic [31:0] md,
                        input bit fire, input bit to_dbg, input logic [31:0] epc,
                        input string tag);
    @(negedge clk);
    if (fire) sb.push_back('{brk: !to_dbg, dbg: to_dbg, pc: epc, tag: tag});
    if_valid = fv; if_pc = pc; if_insn = insn;
    mem_valid = mv; mem_store = st; mem_pc = mpc; mem_addr = ma; mem_data = md;
    @(negedge clk);
    if_valid = 1'b0; mem_valid = 1'b0;
    if (!fire) begin
      check(!brk && !dbg, {tag, " no request"}, {30'd0, brk, dbg}, 32'd0);
    end else begin
      @(negedge clk);
      check(!brk && !dbg, {tag, " single-cycle pulse"}, {30'd0, brk, dbg}, 32'd0);
    end
  endtask

  // monitor: every request must match the head of the scoreboard
  always @(negedge clk) begin
    if (live && (brk || dbg)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected request", {30'd0, brk, dbg}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(brk == e.brk && dbg == e.dbg, {e.tag, " action"}, {30'd0, brk, dbg}, {30'd0, e.brk, e.dbg});
        check(xpc == e.pc, {e.tag, " exception pc"}, xpc, e.pc);
        check(cause == (e.brk ? 4'd3 : 4'd0), {e.tag, " cause"}, {28'd0, cause}, e.brk ? 32'd3 : 32'd0);
      end
    end
  end

  task automatic finish_up();
    while (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      check(1'b0, {e.tag, " missing request"}, 32'd0, e.pc);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // R1 reset state
    csr_chk(TCTL, 32'h2000_0000, "R1 control at reset");
    csr_chk(TCMP, 32'h0, "R1 compare at reset");
    check(!brk && !dbg && cause == 0, "R1 outputs at reset", {28'd0, cause}, 32'd0);

    // R2 / R10 fixed registers and unknown numbers
    csr_chk(TSEL, 32'h0, "R2 selector");
    csr_wr(TSEL, 32'h5);
    csr_chk(TSEL, 32'h0, "R2 selector after write");
    csr_wr(TINFO, 32'hFFFF_FFFF);
    csr_chk(TINFO, 32'h4, "R2 info after write");
    csr_chk(12'h7A5, 32'h0, "R10 unknown number");

    // R3 legalisation
    csr_wr(TCTL, 32'hFFFF_FFFF);
    csr_chk(TCTL, 32'h2008_0047, "R3 all-ones write");
    csr_wr(TCTL, 32'h0000_1044);
    csr_chk(TCTL, 32'h0000_1044, "R3 kind zero");

    // R6 fetch PC kind, breakpoint action
    csr_wr(TCTL, 32'h2000_0044);
    csr_wr(TCMP, 32'h0000_1000);
    csr_chk(TCMP, 32'h0000_1000, "R10 compare readback");
    strobe(1, 32'h1000, 32'h13, 0, 0, 0, 0, 0, 1, 0, 32'h1000, "R6 fetch pc hit");
    strobe(1, 32'h1004, 32'h1000, 0, 0, 0, 0, 0, 0, 0, 0, "R6 fetch pc miss");

    // R6 fetch opcode kind
    csr_wr(TCTL, 32'h2008_0044);
    csr_wr(TCMP, 32'h0010_0073);
    strobe(1, 32'h2000, 32'h0010_0073, 0, 0, 0, 0, 0, 1, 0, 32'h2000, "R6 opcode hit");
    strobe(1, 32'h0010_0073, 32'h13, 0, 0, 0, 0, 0, 0, 0, 0, "R6 opcode miss");

    // R7 store address kind, debug action
    csr_wr(TCTL, 32'h2000_1042);
    csr_wr(TCMP, 32'h8000_0010);
    strobe(0, 0, 0, 1, 1, 32'h3000, 32'h8000_0010, 32'h1, 1, 1, 32'h3004, "R7 store addr hit");
    strobe(0, 0, 0, 1, 0, 32'h3000, 32'h8000_0010, 32'h1, 0, 0, 0, "R7 load to store addr");

    // R7 store data
    csr_wr(TCTL, 32'h2008_1042);
    csr_wr(TCMP, 32'hDEAD_BEEF);
    strobe(0, 0, 0, 1, 1, 32'h3100, 32'h44, 32'hDEAD_BEEF, 1, 1, 32'h3104, "R7 store data hit");

    // R7 load address / data with breakpoint action
    csr_wr(TCTL, 32'h2000_0041);
    csr_wr(TCMP, 32'h0000_4440);
    strobe(0, 0, 0, 1, 0, 32'h3200, 32'h4440, 32'h9, 1, 0, 32'h3204, "R7 load addr hit");
    strobe(0, 0, 0, 1, 1, 32'h3200, 32'h4440, 32'h9, 0, 0, 0, "R7 store to load addr");
    csr_wr(TCTL, 32'h2008_0041);
    strobe(0, 0, 0, 1, 0, 32'h3300, 32'h8, 32'h4440, 1, 0, 32'h3304, "R7 load data hit");

    // R5 illegal combination: execute + load
    csr_wr(TCTL, 32'h2000_0045);
    csr_wr(TCMP, 32'h0000_5000);
    strobe(1, 32'h5000, 32'h5000, 1, 0, 32'h5000, 32'h5000, 32'h5000, 0, 0, 0, "R5 illegal kind");

    // R9 disarming conditions
    csr_wr(TCTL, 32'h2000_0004);
    strobe(1, 32'h5000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 machine enable off");
    csr_wr(TCTL, 32'h0000_0044);
    strobe(1, 32'h5000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 kind zero");
    csr_wr(TCTL, 32'h2000_0044);
    debug_mode = 1'b1;
    strobe(1, 32'h5000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 in debug mode");
    debug_mode = 1'b0;
    strobe(1, 32'h5000, 0, 0, 0, 0, 0, 0, 1, 0, 32'h5000, "R9 re-armed");

    // R4 debugger ownership
    csr_wr(TCTL, 32'h2800_1044);
    csr_chk(TCTL, 32'h2000_1044, "R4 owner flag outside debug");
    debug_mode = 1'b1;
    csr_wr(TCTL, 32'h2800_1044);
    debug_mode = 1'b0;
    csr_chk(TCTL, 32'h2800_1044, "R4 owner flag in debug");
    csr_wr(TCMP, 32'h0000_1234);
    csr_chk(TCMP, 32'h0000_5000, "R4 compare locked");
    csr_wr(TCTL, 32'h0);
    csr_chk(TCTL, 32'h2800_1044, "R4 control locked");
    strobe(1, 32'h5000, 0, 0, 0, 0, 0, 0, 1, 1, 32'h5000, "R4 owned trigger fires");

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_up();
  end
endmodule